// File: doc/BRIEF.md
# Indirect Register Addressing Unit

This block resolves the register-file address for every data access of an 8-bit accumulator core. A direct access names a register through a 7-bit in-instruction offset, and a bank-select value supplies the upper address bits. Two offsets are reserved in every bank. One holds a pointer register that lives inside this block. The other is an alias that has no storage of its own: any read or write of the alias is sent to the register whose full 8-bit number sits in the pointer.

An access that goes through the alias can also move the pointer by one, up or down, before or after the access. This lets software walk through tables or use the pointer as a software stack pointer. The block drives a registered request to the register-file array: address, read and write strobes, and write data. It also drives a read-source code that tells the datapath whether read data comes from the array, from this block's pointer, or is forced to zero. The array and instruction decode sit outside the block.

Top module: `ind_addr_unit`

## Requirements
- R1: After synchronous reset the pointer is 0x00, both register-file strobes are low and the read-source code is 0.
- R2: A direct access to an offset other than 0x00 or 0x04 drives the address {bank, offset}, its read/write strobes and its write data one clock later, with read-source code 0 (array).
- R3: A direct write to offset 0x04 loads the pointer with the write data, visible one clock later, and raises no array strobe. A direct read of offset 0x04 raises no array strobe and gives read-source code 2 (pointer).
- R4: A read or write of offset 0x00 is redirected to the full 8-bit pointer value as address, in any bank. The bank input is ignored.
- R5: Mode 1 (post-increment) and mode 2 (post-decrement) on an alias access use the old pointer as address, then leave the pointer one higher or lower.
- R6: Mode 3 (pre-increment) and mode 4 (pre-decrement) on an alias access step the pointer first and use the new value as address, and the pointer keeps that new value.
- R7: Pointer stepping wraps modulo 256 (0xFF+1 gives 0x00, 0x00-1 gives 0xFF).
- R8: If the pointer used for an alias access has low 7 bits equal to 0x00 or 0x04, no array strobe is raised, a read gives read-source code 1 (zero), and a write changes nothing except any pointer step the mode asks for.
- R9: The mode is ignored on direct accesses and in cycles with no strobe. Modes 0 and 5 to 7 leave the pointer unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| acc_rd | input | 1 | Access read strobe |
| acc_wr | input | 1 | Access write strobe |
| acc_bank | input | ADDR_W-OFF_W | Bank-select bits for direct accesses |
| acc_off | input | OFF_W | Direct register offset from the instruction |
| acc_mode | input | 3 | Pointer step mode for alias accesses |
| acc_wdata | input | DATA_W | Write data |
| rf_addr | output | ADDR_W | Effective register-file address |
| rf_rd | output | 1 | Register-file read strobe |
| rf_wr | output | 1 | Register-file write strobe |
| rf_wdata | output | DATA_W | Register-file write data |
| rd_src | output | 2 | Read-data source: 0 array, 1 zero, 2 pointer |
| ptr_value | output | ADDR_W | Current pointer contents |

## Verification
A corrupted pointer shows up one clock after the faulty update, on ptr_value. It shows again on rf_addr at the next alias access. A step in the wrong direction, or on the wrong side of the access, shows as an address that is off by one in that very cycle. A faulty reserved-offset check shows as an array strobe on offset 0x00 or 0x04, or as a missing zero read-source, one clock after the access. The random mix keeps the pointer moving and compares every alias access against the model, so a drift is caught at the next alias access.

// File: rtl/ind_addr_pkg.sv
package ind_addr_pkg;

  typedef enum logic [1:0] {
    SRC_ARRAY = 2'd0,
    SRC_ZERO  = 2'd1,
    SRC_PTR   = 2'd2
  } rd_src_e;

  localparam logic [2:0] MODE_POST_INC = 3'd1;
  localparam logic [2:0] MODE_POST_DEC = 3'd2;
  localparam logic [2:0] MODE_PRE_INC  = 3'd3;
  localparam logic [2:0] MODE_PRE_DEC  = 3'd4;

  typedef struct packed {
    logic pre;
    logic post;
    logic down;
  } step_ctl_t;

  function automatic step_ctl_t decode_mode(input logic [2:0] m);
    step_ctl_t s;
    s.pre  = (m == MODE_PRE_INC)  || (m == MODE_PRE_DEC);
    s.post = (m == MODE_POST_INC) || (m == MODE_POST_DEC);
    s.down = (m == MODE_POST_DEC) || (m == MODE_PRE_DEC);
    return s;
  endfunction

endpackage

// File: rtl/iru_classify.sv
module iru_classify #(
  parameter int unsigned OFF_W = 7,
  parameter logic [OFF_W-1:0] ALIAS_OFF = '0,
  parameter logic [OFF_W-1:0] PTR_OFF = 4
) (
  input  logic [OFF_W-1:0] off,
  output logic             is_alias,
  output logic             is_ptr
);
  assign is_alias = (off == ALIAS_OFF);
  assign is_ptr   = (off == PTR_OFF);
endmodule

// File: rtl/iru_pointer.sv
module iru_pointer #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         step_en,
  input  logic         step_down,
  output logic [W-1:0] ptr_q,
  output logic [W-1:0] ptr_step
);
  localparam logic [W-1:0] ONE = {{(W-1){1'b0}}, 1'b1};

  // modulo-2^W neighbour in the requested direction
  assign ptr_step = step_down ? (ptr_q - ONE) : (ptr_q + ONE);

  always_ff @(posedge clk) begin
    if (rst)          ptr_q <= '0;
    else if (load)    ptr_q <= load_val;
    else if (step_en) ptr_q <= ptr_step;
  end
endmodule

// File: rtl/iru_outreg.sv
module iru_outreg #(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] n_addr,
  input  logic              n_rd,
  input  logic              n_wr,
  input  logic [DATA_W-1:0] n_wdata,
  input  logic [1:0]        n_src,
  output logic [ADDR_W-1:0] q_addr,
  output logic              q_rd,
  output logic              q_wr,
  output logic [DATA_W-1:0] q_wdata,
  output logic [1:0]        q_src
);
  always_ff @(posedge clk) begin
    if (rst) begin
      q_addr  <= '0;
      q_rd    <= 1'b0;
      q_wr    <= 1'b0;
      q_wdata <= '0;
      q_src   <= 2'd0;
    end else begin
      q_addr  <= n_addr;
      q_rd    <= n_rd;
      q_wr    <= n_wr;
      q_wdata <= n_wdata;
      q_src   <= n_src;
    end
  end
endmodule

// File: rtl/ind_addr_unit.sv
module ind_addr_unit
  import ind_addr_pkg::*;
#(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned OFF_W  = 7,
  parameter int unsigned DATA_W = 8,
  parameter logic [OFF_W-1:0] ALIAS_OFF = '0,
  parameter logic [OFF_W-1:0] PTR_OFF   = 4
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    acc_rd,
  input  logic                    acc_wr,
  input  logic [ADDR_W-OFF_W-1:0] acc_bank,
  input  logic [OFF_W-1:0]        acc_off,
  input  logic [2:0]              acc_mode,
  input  logic [DATA_W-1:0]       acc_wdata,
  output logic [ADDR_W-1:0]       rf_addr,
  output logic                    rf_rd,
  output logic                    rf_wr,
  output logic [DATA_W-1:0]       rf_wdata,
  output logic [1:0]              rd_src,
  output logic [ADDR_W-1:0]       ptr_value
);
  localparam int unsigned BANK_W = ADDR_W - OFF_W;

  logic              access, via_alias, d_alias, d_ptr;
  logic              p_alias, p_ptr, null_tgt;
  step_ctl_t         step;
  logic [ADDR_W-1:0] ptr_q, ptr_step, eff_ptr, direct_addr;
  logic [ADDR_W-1:0] n_addr;
  logic              n_rd, n_wr;
  rd_src_e           n_src;

  assign access      = acc_rd | acc_wr;
  assign step        = decode_mode(acc_mode);
  assign direct_addr = {acc_bank, acc_off};

  iru_classify #(.OFF_W(OFF_W), .ALIAS_OFF(ALIAS_OFF), .PTR_OFF(PTR_OFF)) u_cls_dir (
    .off      (acc_off),
    .is_alias (d_alias),
    .is_ptr   (d_ptr)
  );

  assign via_alias = access & d_alias;

  iru_pointer #(.W(ADDR_W)) u_ptr (
    .clk       (clk),
    .rst       (rst),
    .load      (acc_wr & d_ptr),
    .load_val  (acc_wdata[ADDR_W-1:0]),
    .step_en   (via_alias & (step.pre | step.post)),
    .step_down (step.down),
    .ptr_q     (ptr_q),
    .ptr_step  (ptr_step)
  );

  // pre-modify addresses through the stepped value, otherwise the held one
  assign eff_ptr = step.pre ? ptr_step : ptr_q;

  iru_classify #(.OFF_W(OFF_W), .ALIAS_OFF(ALIAS_OFF), .PTR_OFF(PTR_OFF)) u_cls_ind (
    .off      (eff_ptr[OFF_W-1:0]),
    .is_alias (p_alias),
    .is_ptr   (p_ptr)
  );

  assign null_tgt = p_alias | p_ptr;

  always_comb begin
    n_addr = direct_addr;
    n_rd   = acc_rd;
    n_wr   = acc_wr;
    n_src  = SRC_ARRAY;
    if (via_alias) begin
      n_addr = eff_ptr;
      n_rd   = acc_rd & ~null_tgt;
      n_wr   = acc_wr & ~null_tgt;
      if (acc_rd && null_tgt) n_src = SRC_ZERO;
    end else if (d_ptr) begin
      n_rd = 1'b0;
      n_wr = 1'b0;
      if (acc_rd) n_src = SRC_PTR;
    end
  end

  iru_outreg #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_out (
    .clk     (clk),
    .rst     (rst),
    .n_addr  (n_addr),
    .n_rd    (n_rd),
    .n_wr    (n_wr),
    .n_wdata (acc_wdata),
    .n_src   (n_src),
    .q_addr  (rf_addr),
    .q_rd    (rf_rd),
    .q_wr    (rf_wr),
    .q_wdata (rf_wdata),
    .q_src   (rd_src)
  );

  assign ptr_value = ptr_q;

  logic unused_bank_w;
  assign unused_bank_w = (BANK_W == 0);
endmodule

// File: rtl/iru_checker.sv
module iru_checker #(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned OFF_W  = 7,
  parameter int unsigned DATA_W = 8,
  parameter logic [OFF_W-1:0] ALIAS_OFF = '0,
  parameter logic [OFF_W-1:0] PTR_OFF   = 4
) (
  input logic                    clk,
  input logic                    rst,
  input logic                    acc_rd,
  input logic                    acc_wr,
  input logic [ADDR_W-OFF_W-1:0] acc_bank,
  input logic [OFF_W-1:0]        acc_off,
  input logic [2:0]              acc_mode,
  input logic [DATA_W-1:0]       acc_wdata,
  input logic [ADDR_W-1:0]       rf_addr,
  input logic                    rf_rd,
  input logic                    rf_wr,
  input logic [1:0]              rd_src,
  input logic [ADDR_W-1:0]       ptr_value
);
  localparam logic [ADDR_W-1:0] ONE = {{(ADDR_W-1){1'b0}}, 1'b1};

  assert_reset_state_R1: assert property (@(posedge clk)
    $fell(rst) |-> (ptr_value == '0) && !rf_rd && !rf_wr && (rd_src == 2'd0));

  assert_direct_pass_R2: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(acc_rd) && ($past(acc_off) != ALIAS_OFF) && ($past(acc_off) != PTR_OFF))
      |-> rf_rd && (rf_addr == $past({acc_bank, acc_off})));

  assert_ptr_load_R3: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(acc_wr) && ($past(acc_off) == PTR_OFF))
      |-> (ptr_value == $past(acc_wdata[ADDR_W-1:0])) && !rf_wr);

  assert_post_inc_R5: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(acc_rd || acc_wr) && ($past(acc_off) == ALIAS_OFF) && ($past(acc_mode) == 3'd1))
      |-> (ptr_value == ($past(ptr_value) + ONE)));

  assert_no_reserved_target_R8: assert property (@(posedge clk) disable iff (rst)
    (rf_rd || rf_wr) |-> (rf_addr[OFF_W-1:0] != ALIAS_OFF) && (rf_addr[OFF_W-1:0] != PTR_OFF));

  assert_idle_hold_R9: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(acc_rd) && !$past(acc_wr)) |-> $stable(ptr_value));
endmodule

bind ind_addr_unit iru_checker #(
  .ADDR_W(ADDR_W), .OFF_W(OFF_W), .DATA_W(DATA_W),
  .ALIAS_OFF(ALIAS_OFF), .PTR_OFF(PTR_OFF)
) u_chk (
  .clk(clk), .rst(rst), .acc_rd(acc_rd), .acc_wr(acc_wr), .acc_bank(acc_bank),
  .acc_off(acc_off), .acc_mode(acc_mode), .acc_wdata(acc_wdata), .rf_addr(rf_addr),
  .rf_rd(rf_rd), .rf_wr(rf_wr), .rd_src(rd_src), .ptr_value(ptr_value)
);

// File: tb/sim_ind_addr_unit.sv
`timescale 1ns/1ps
module sim_ind_addr_unit;
  logic       clk = 1'b0;
  logic       rst;
  logic       acc_rd, acc_wr;
  logic [0:0] acc_bank;
  logic [6:0] acc_off;
  logic [2:0] acc_mode;
  logic [7:0] acc_wdata;
  logic [7:0] rf_addr, rf_wdata, ptr_value;
  logic       rf_rd, rf_wr;
  logic [1:0] rd_src;

  int checks = 0;
  int errors = 0;
  logic [7:0] mptr;

  always #2.5 clk = ~clk;

  ind_addr_unit u0 (
    .clk(clk), .rst(rst), .acc_rd(acc_rd), .acc_wr(acc_wr), .acc_bank(acc_bank),
    .acc_off(acc_off), .acc_mode(acc_mode), .acc_wdata(acc_wdata), .rf_addr(rf_addr),
    .rf_rd(rf_rd), .rf_wr(rf_wr), .rf_wdata(rf_wdata), .rd_src(rd_src), .ptr_value(ptr_value)
  );

  task automatic chk(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  // drive one access at a falling edge, check its registered result one clock later
  task automatic do_op(input logic rd, input logic wr, input logic [0:0] bank,
                       input logic [6:0] off, input logic [2:0] mode, input logic [7:0] wd);
    logic pre, post, dn, nul;
    logic [7:0] stepped, eptr, e_addr;
    logic e_rd, e_wr;
    int e_src;
    string tag;
    acc_rd = rd; acc_wr = wr; acc_bank = bank; acc_off = off; acc_mode = mode; acc_wdata = wd;
    pre  = (mode == 3'd3) || (mode == 3'd4);
    post = (mode == 3'd1) || (mode == 3'd2);
    dn   = (mode == 3'd2) || (mode == 3'd4);
    stepped = dn ? mptr - 8'd1 : mptr + 8'd1;
    e_addr = {bank, off}; e_rd = rd; e_wr = wr; e_src = 0; tag = "R2";
    if ((rd || wr) && off == 7'h00) begin
      eptr = pre ? stepped : mptr;
      nul  = (eptr[6:0] == 7'h00) || (eptr[6:0] == 7'h04);
      e_addr = eptr; e_rd = rd && !nul; e_wr = wr && !nul;
      e_src = (rd && nul) ? 1 : 0;
      tag = nul ? "R8" : pre ? "R6" : post ? "R5" : "R4";
      if (pre || post) mptr = stepped;
    end else if (off == 7'h04) begin
      e_rd = 1'b0; e_wr = 1'b0; e_src = rd ? 2 : 0; tag = "R3";
      if (wr) mptr = wd;
    end else if (!rd && !wr) begin
      tag = "R9";
    end
    @(posedge clk);
    @(negedge clk);
    chk(tag, "rf_rd", rf_rd, e_rd);
    chk(tag, "rf_wr", rf_wr, e_wr);
    chk(tag, "rd_src", rd_src, e_src);
    if (e_rd || e_wr) chk(tag, "rf_addr", rf_addr, e_addr);
    if (e_wr) chk(tag, "rf_wdata", rf_wdata, wd);
    chk(tag, "ptr_value", ptr_value, mptr);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    rst = 1'b1; acc_rd = 0; acc_wr = 0; acc_bank = 0; acc_off = 0; acc_mode = 0; acc_wdata = 0;
    mptr = 8'h00;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    chk("R1", "ptr_value", ptr_value, 0);
    chk("R1", "rf_rd", rf_rd, 0);
    chk("R1", "rf_wr", rf_wr, 0);
    chk("R1", "rd_src", rd_src, 0);

    // direct accesses in both banks
    do_op(1, 0, 1'b1, 7'h23, 3'd0, 8'h00);
    do_op(0, 1, 1'b0, 7'h7F, 3'd3, 8'hA5);
    // pointer load, readback, alias ignores bank
    do_op(0, 1, 1'b1, 7'h04, 3'd0, 8'h30);
    do_op(1, 0, 1'b0, 7'h04, 3'd0, 8'h00);
    do_op(1, 0, 1'b1, 7'h00, 3'd0, 8'h00);
    chk("R4", "rf_addr bank ignored", rf_addr, 8'h30);
    // mode ignored when idle or direct
    do_op(0, 0, 1'b0, 7'h00, 3'd1, 8'h00);
    do_op(1, 0, 1'b0, 7'h11, 3'd3, 8'h00);
    chk("R9", "ptr unchanged", ptr_value, 8'h30);
    // wrap-around
    do_op(0, 1, 1'b0, 7'h04, 3'd0, 8'hFF);
    do_op(0, 1, 1'b0, 7'h00, 3'd1, 8'h5A);
    chk("R7", "post-inc wrap", ptr_value, 8'h00);
    do_op(1, 0, 1'b0, 7'h00, 3'd4, 8'h00);
    chk("R7", "pre-dec wrap addr", rf_addr, 8'hFF);
    chk("R7", "pre-dec wrap ptr", ptr_value, 8'hFF);
    // pointer naming reserved offsets
    do_op(0, 1, 1'b0, 7'h04, 3'd0, 8'h80);
    do_op(1, 0, 1'b0, 7'h00, 3'd0, 8'h00);
    chk("R8", "zero source", rd_src, 1);
    do_op(0, 1, 1'b0, 7'h04, 3'd0, 8'h03);
    do_op(0, 1, 1'b0, 7'h00, 3'd3, 8'hEE);
    chk("R8", "dropped write, ptr stepped", ptr_value, 8'h04);
    do_op(1, 0, 1'b0, 7'h00, 3'd2, 8'h00);
    chk("R5", "post-dec ptr", ptr_value, 8'h03);

    for (int i = 0; i < 4000; i++) begin
      logic [6:0] off;
      int pick;
      pick = $urandom % 8;
      off = (pick < 3) ? 7'h00 : (pick == 3) ? 7'h04 : 7'($urandom);
      do_op(1'($urandom), 1'($urandom), 1'($urandom), off, 3'($urandom), 8'($urandom));
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule